// File: doc/BRIEF.md
# Word-Configured SPI Master with Frame Continuation

This block is an SPI master controlled through a two-address write port. Address 0 holds a configuration word. It sets the transfer length, the SCLK divider, the chip-select field and eight mode flags, and every later transfer follows it until it is rewritten. Address 1 takes a data word. Each accepted data write starts exactly one transfer, which shifts the word out on MOSI while SCLK toggles and the selected chip-select lines are active.

Two flags let one frame span several words. The last-word flag decides whether chip select is dropped once the word ends or held for a following word. The capture flag decides whether the bits sampled from MISO are pushed into a small read queue, where software drains them through a valid/ready read port. A typical use is a readback: a command word with capture off, a configuration rewrite, then a dummy word with capture on.

Top module: `spi_frame_master`

## Requirements
- R1: Configuration word layout. Bit 0 is offline, bit 1 last-word, bit 2 capture, bit 3 chip-select-active-high, bit 4 SCLK-idle-high, bit 5 late-phase, bit 6 LSB-first and bit 7 half-duplex. Bits 12:8 hold the bit count minus one (1 to 32 bits). Bits 23:16 hold the divider and bits 31:24 the chip-select field. Address 0 selects this word and address 1 the data word.
- R2: In the default one-hot mode, bit 24+n of the configuration word selects chip-select line n. With a parameter the field is read as a binary line number instead. Selected lines are driven low during a transfer, or high when bit 3 is set, and every other line sits at the inactive level.
- R3: The SCLK half-period is max(divider, 2) system cycles, called D. A transfer of N bits gives exactly 2N SCLK edges, and busy is high for exactly (2N+1)*D cycles, starting the cycle after the data write is accepted.
- R4: The low N bits of the data word are sent, most significant first, or least significant first when bit 6 is set.
- R5: SCLK rests at the level of bit 4. With bit 5 clear, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With bit 5 set, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R6: With capture set, the N received bits are pushed into the read queue, right-aligned, with the first received bit as the most significant (MSB-first) or as bit 0 (LSB-first). With capture clear, nothing is pushed.
- R7: With last-word set, chip select goes inactive when busy falls. With it clear, chip select stays active through configuration rewrites until a later word ends with last-word set, or until offline is written.
- R8: wr_ready is low whenever busy is high, so writes of either address are held off during a transfer.
- R9: The read queue holds RX_DEPTH words (default 4) in order. A word captured while the queue is full is dropped. A push and a pop in the same cycle both take effect.
- R10: With offline set, SCLK sits at its idle level, MOSI and mosi_oe are low, and all chip selects are inactive, including one held from an unfinished frame. A data write is accepted and discarded without raising busy.
- R11: mosi_oe is low when half-duplex and capture are both set, and high otherwise while online.
- R12: After reset, busy is 0, wr_ready is 1, all chip selects are high, SCLK and MOSI are 0 and rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high (low while busy) |
| wr_addr | input | 1 | 0 = configuration word, 1 = data word |
| wr_data | input | 32 | Write payload |
| rd_valid | output | 1 | Read queue holds a word |
| rd_ready | input | 1 | Pops the head word when rd_valid is high |
| rd_data | output | 32 | Head word of the read queue |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for MOSI |
| miso | input | 1 | Serial data in |
| cs_line | output | N_CS | Chip-select lines |

## Verification
A word that has just been captured, and a software pop from the read queue, can land on the same clock edge. The capture push comes out on the edge where busy falls, and the queue's head is popped by rd_ready on the following edge. The bench leaves one word in the queue, runs a captured transfer and raises rd_ready in the very cycle it first sees busy low. It then checks that the popped word was the old head, that the new word is now at the head, and that one further pop empties the queue. The queue-full drop is checked separately with five captures and no pops.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int WORD_W  = 32;
    localparam int MIN_DIV = 2;

    // Mode flags, bit 0 is offline
    typedef struct packed {
        logic half;        // 7
        logic lsb;         // 6
        logic ck_late;     // 5
        logic ck_idle_hi;  // 4
        logic cs_hi;       // 3
        logic capture;     // 2
        logic last;        // 1
        logic offline;     // 0
    } flags_t;

    typedef struct packed {
        logic [7:0] sel;     // 31:24
        logic [7:0] div;     // 23:16
        logic [2:0] rsvd;    // 15:13
        logic [4:0] len_m1;  // 12:8
        flags_t     fl;      // 7:0
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL
    } eng_st_t;

    function automatic logic [7:0] half_period(input logic [7:0] div);
        return (div < 8'(MIN_DIV)) ? 8'(MIN_DIV) : div;
    endfunction

    function automatic logic [5:0] bit_count(input logic [4:0] len_m1);
        return {1'b0, len_m1} + 6'd1;
    endfunction

endpackage

// File: rtl/spim_cfg.sv
module spim_cfg
    import spim_pkg::*;
#(
    parameter int N_CS      = 4,
    parameter bit CS_ONEHOT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [WORD_W-1:0]      cfg_word,
    output cfg_t                   cfg,
    output logic [N_CS-1:0]        sel_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_we) begin
            cfg <= cfg_t'(cfg_word);
        end
    end

    generate
        if (CS_ONEHOT) begin : g_onehot
            for (genvar i = 0; i < N_CS; i++) begin : g_line
                if (i < 8) begin : g_in
                    assign sel_mask[i] = cfg.sel[i];
                end else begin : g_out
                    assign sel_mask[i] = 1'b0;
                end
            end
        end else begin : g_binary
            for (genvar i = 0; i < N_CS; i++) begin : g_line
                assign sel_mask[i] = (cfg.sel == 8'(i));
            end
        end
    endgenerate

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int N_CS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WORD_W-1:0]  tx_word,
    input  cfg_t               cfg,
    input  logic [N_CS-1:0]    sel_mask,
    input  logic               miso,
    output logic               busy,
    output logic               sclk,
    output logic               mosi,
    output logic               mosi_oe,
    output logic [N_CS-1:0]    cs_line,
    output logic               push,
    output logic [WORD_W-1:0]  push_word
);

    localparam int EDGE_W = $clog2(2 * WORD_W) + 1;

    eng_st_t            st;
    logic [7:0]         cnt;
    logic [EDGE_W-1:0]  edge_k;
    logic [WORD_W-1:0]  tx_sr;
    logic [WORD_W-1:0]  rx_sr;
    logic               sck_ph;
    logic               cs_act;

    logic [7:0]         hp;
    logic [5:0]         nbits;
    logic [5:0]         pad;
    logic [EDGE_W-1:0]  last_edge;
    logic               tick;
    logic               leading;
    logic               sample_now;
    logic               shift_now;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg.rsvd, cfg.sel};

    assign hp         = half_period(cfg.div);
    assign nbits      = bit_count(cfg.len_m1);
    assign pad        = 6'd32 - nbits;
    assign last_edge  = EDGE_W'({nbits, 1'b0}) - EDGE_W'(1);
    assign tick       = (st != ST_IDLE) && (cnt == hp - 8'd1);
    assign leading    = ~edge_k[0];
    assign sample_now = cfg.fl.ck_late ? ~leading : leading;
    // late phase: the first leading edge presents bit 0, which is already on MOSI
    assign shift_now  = ~sample_now && !(cfg.fl.ck_late && edge_k == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            edge_k    <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            sck_ph    <= 1'b0;
            cs_act    <= 1'b0;
            push      <= 1'b0;
            push_word <= '0;
        end else begin
            push <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (cfg.fl.offline) begin
                        cs_act <= 1'b0;
                    end else if (start) begin
                        tx_sr  <= cfg.fl.lsb ? tx_word : (tx_word << pad);
                        rx_sr  <= '0;
                        cnt    <= '0;
                        edge_k <= '0;
                        cs_act <= 1'b1;
                        st     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        cnt    <= '0;
                        sck_ph <= ~sck_ph;
                        edge_k <= edge_k + EDGE_W'(1);
                        if (sample_now) begin
                            rx_sr <= cfg.fl.lsb ? {miso, rx_sr[WORD_W-1:1]}
                                                : {rx_sr[WORD_W-2:0], miso};
                        end else if (shift_now) begin
                            tx_sr <= cfg.fl.lsb ? (tx_sr >> 1) : (tx_sr << 1);
                        end
                        if (edge_k == last_edge) begin
                            st <= ST_TAIL;
                        end
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cnt       <= '0;
                        st        <= ST_IDLE;
                        cs_act    <= ~cfg.fl.last;
                        push      <= cfg.fl.capture;
                        push_word <= cfg.fl.lsb ? (rx_sr >> pad) : rx_sr;
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign sclk    = cfg.fl.offline ? cfg.fl.ck_idle_hi : (sck_ph ^ cfg.fl.ck_idle_hi);
    assign mosi    = (cfg.fl.offline || !cs_act) ? 1'b0
                   : (cfg.fl.lsb ? tx_sr[0] : tx_sr[WORD_W-1]);
    assign mosi_oe = ~cfg.fl.offline & ~(cfg.fl.half & cfg.fl.capture);

    generate
        for (genvar i = 0; i < N_CS; i++) begin : g_cs
            assign cs_line[i] = (cs_act && !cfg.fl.offline && sel_mask[i])
                              ? cfg.fl.cs_hi : ~cfg.fl.cs_hi;
        end
    endgenerate

    // R10
    run_online_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cfg.fl.offline);

    // R5
    sclk_park_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (sclk == cfg.fl.ck_idle_hi));

    // R6
    push_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> ($past(busy) && !busy));

endmodule

// File: rtl/spim_rxq.sv
module spim_rxq #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_word,
    input  logic          pop_req,
    output logic          rd_valid,
    output logic [W-1:0]  rd_word
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] count;
    logic          pop;
    logic          room;
    logic          wr;

    assign rd_valid = (count != '0);
    assign rd_word  = mem[rp];
    assign pop      = pop_req & rd_valid;
    assign room     = (count != CW'(DEPTH)) | pop;
    assign wr       = push & room;

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[wp] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            end
            count <= count + CW'(wr) - CW'(pop);
        end
    end

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && push && !pop_req) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spim_pkg::*;
#(
    parameter int N_CS      = 4,
    parameter bit CS_ONEHOT = 1'b1,
    parameter int RX_DEPTH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic             wr_addr,
    input  logic [31:0]      wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [31:0]      rd_data,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    output logic             mosi_oe,
    input  logic             miso,
    output logic [N_CS-1:0]  cs_line
);

    cfg_t              cfg;
    logic [N_CS-1:0]   sel_mask;
    logic              cfg_we;
    logic              start;
    logic              push;
    logic [WORD_W-1:0] push_word;

    assign wr_ready = ~busy;
    assign cfg_we   = wr_valid & wr_ready & ~wr_addr;
    assign start    = wr_valid & wr_ready &  wr_addr;

    spim_cfg #(.N_CS(N_CS), .CS_ONEHOT(CS_ONEHOT)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_word (wr_data),
        .cfg      (cfg),
        .sel_mask (sel_mask)
    );

    spim_engine #(.N_CS(N_CS)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tx_word   (wr_data),
        .cfg       (cfg),
        .sel_mask  (sel_mask),
        .miso      (miso),
        .busy      (busy),
        .sclk      (sclk),
        .mosi      (mosi),
        .mosi_oe   (mosi_oe),
        .cs_line   (cs_line),
        .push      (push),
        .push_word (push_word)
    );

    spim_rxq #(.DEPTH(RX_DEPTH), .W(WORD_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_word (push_word),
        .pop_req   (rd_ready),
        .rd_valid  (rd_valid),
        .rd_word   (rd_data)
    );

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_addr && !cfg.fl.offline) |=> busy);

    // R8
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_ready);

    // R2
    cs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg.fl.cs_hi) |-> ((cs_line & sel_mask) == '0));

endmodule

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data;
    logic        busy;
    logic        sclk;
    logic        mosi;
    logic        mosi_oe;
    logic        miso = 1'b0;
    logic [3:0]  cs_line;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] cur_cfg = '0;
    logic [31:0] got;
    int          edges;
    int          cyc;
    logic [3:0]  cs_seen;
    bit          ready_bad;

    always #5 clk = ~clk;

    spi_frame_master i_spi_frame_master (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy), .sclk(sclk),
        .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso), .cs_line(cs_line)
    );

    // stimulus: config word, data word, slave MISO pattern
    localparam int NV = 6;
    localparam logic [31:0] VCFG [NV] = '{
        32'h0102_0706, 32'h0203_1726, 32'h0400_0F56,
        32'h0804_1F36, 32'h0105_0402, 32'h0302_0B66 };
    localparam logic [31:0] VDAT [NV] = '{
        32'h0000_00A5, 32'h0012_3456, 32'h0000_BEEF,
        32'hDEAD_BEEF, 32'h0000_0013, 32'h0000_0ABC };
    localparam logic [31:0] VPAT [NV] = '{
        32'h3C00_0000, 32'hC0FF_EE00, 32'h1234_0000,
        32'h8765_4321, 32'hF800_0000, 32'h5A50_0000 };

    function automatic logic [31:0] rev_n(input logic [31:0] v, input int n);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = v[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [31:0] w);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 1'b0; wr_data = w;
        @(negedge clk);
        wr_valid = 1'b0;
        cur_cfg = w;
    endtask

    task automatic pop_chk(input string tag, input logic [31:0] exp);
        @(negedge clk);
        check({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
        check({tag, " rd_data"}, rd_data, exp);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    // one data word with a slave model on SCLK edges
    task automatic xfer(input logic [31:0] d, input logic [31:0] pat,
                        input bit pop_at_end, input logic [31:0] pop_exp);
        logic [31:0] p;
        logic prev;
        bit lead;
        bit pha;
        bit pol;
        pha = cur_cfg[5];
        pol = cur_cfg[4];
        p = pat; got = '0; edges = 0; cyc = 0; cs_seen = 4'hx; ready_bad = 0;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 1'b1; wr_data = d;
        if (!pha) begin miso = p[31]; p = p << 1; end
        prev = sclk;
        @(negedge clk);
        wr_valid = 1'b0;
        while (1) begin
            if (sclk != prev) begin
                edges++;
                lead = (sclk != pol);
                if (edges == 1) cs_seen = cs_line;
                if (lead ^ pha) got = {got[30:0], mosi};
                else begin miso = p[31]; p = p << 1; end
                prev = sclk;
            end
            if (!busy) break;
            cyc++;
            if (wr_ready) ready_bad = 1;
            @(negedge clk);
        end
        if (pop_at_end) begin
            check("R9 same-cycle rd_valid", {31'b0, rd_valid}, 32'd1);
            check("R9 same-cycle old head", rd_data, pop_exp);
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog R3 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 busy", {31'b0, busy}, 32'd0);
        check("R12 wr_ready", {31'b0, wr_ready}, 32'd1);
        check("R12 cs_line", {28'b0, cs_line}, 32'hF);
        check("R12 sclk", {31'b0, sclk}, 32'd0);
        check("R12 mosi", {31'b0, mosi}, 32'd0);
        check("R12 rd_valid", {31'b0, rd_valid}, 32'd0);

        // table walk: R1 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            int n;
            int dv;
            logic [31:0] msk;
            logic [31:0] mexp;
            logic [31:0] rexp;
            wr_cfg(VCFG[v]);
            n = int'(VCFG[v][12:8]) + 1;
            dv = (VCFG[v][23:16] < 8'd2) ? 2 : int'(VCFG[v][23:16]);
            msk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
            mexp = VCFG[v][6] ? rev_n(VDAT[v], n) : (VDAT[v] & msk);
            rexp = VPAT[v] >> (32 - n);
            if (VCFG[v][6]) rexp = rev_n(rexp, n);
            xfer(VDAT[v], VPAT[v], 1'b0, '0);
            check("R3 edge count", edges, 2 * n);
            check("R3 busy cycles", cyc, (2 * n + 1) * dv);
            check("R4 mosi bits", got, mexp);
            check("R2 cs during word", {28'b0, cs_seen}, {28'b0, ~VCFG[v][27:24]});
            check("R8 held off", {31'b0, ready_bad}, 32'd0);
            check("R7 cs released", {28'b0, cs_line}, 32'hF);
            check("R5 sclk idle", {31'b0, sclk}, {31'b0, VCFG[v][4]});
            if (VCFG[v][2]) pop_chk("R6 captured word", rexp);
            else begin
                @(negedge clk);
                check("R6 no capture", {31'b0, rd_valid}, 32'd0);
            end
        end

        // R7 continuation: cs held across a config rewrite
        wr_cfg(32'h0102_0700);
        xfer(32'h5A, 32'h0, 1'b0, '0);
        check("R7 cs held", {28'b0, cs_line}, 32'hE);
        wr_cfg(32'h0102_0706);
        check("R7 cs held over config", {28'b0, cs_line}, 32'hE);
        xfer(32'h81, 32'hFF00_0000, 1'b0, '0);
        check("R7 cs released at end", {28'b0, cs_line}, 32'hF);
        pop_chk("R6 only captured word", 32'hFF);
        @(negedge clk);
        check("R6 uncaptured word absent", {31'b0, rd_valid}, 32'd0);

        // R10 offline drops a held frame and ignores data
        wr_cfg(32'h0102_0700);
        xfer(32'h33, 32'h0, 1'b0, '0);
        check("R10 cs held before offline", {28'b0, cs_line}, 32'hE);
        wr_cfg(32'h0102_0701);
        check("R10 cs inactive", {28'b0, cs_line}, 32'hF);
        check("R10 mosi", {31'b0, mosi}, 32'd0);
        check("R10 mosi_oe", {31'b0, mosi_oe}, 32'd0);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 1'b1; wr_data = 32'hFF;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R10 no busy", {31'b0, busy}, 32'd0);
        repeat (6) @(negedge clk);
        check("R10 sclk idle", {31'b0, sclk}, 32'd0);
        check("R10 cs stays inactive", {28'b0, cs_line}, 32'hF);

        // R11 half duplex
        wr_cfg(32'h0102_0784);
        check("R11 mosi_oe off", {31'b0, mosi_oe}, 32'd0);
        wr_cfg(32'h0102_0780);
        check("R11 mosi_oe on", {31'b0, mosi_oe}, 32'd1);

        // R2 active-high selects, two lines
        wr_cfg(32'h0502_070A);
        check("R2 idle active-high", {28'b0, cs_line}, 32'h0);
        xfer(32'hC3, 32'h0, 1'b0, '0);
        check("R2 active-high during", {28'b0, cs_seen}, 32'h5);
        check("R2 active-high released", {28'b0, cs_line}, 32'h0);

        // R9 queue full: five captures, four kept
        wr_cfg(32'h0102_0306);
        for (int k = 1; k <= 5; k++) xfer(32'h0, 32'(k) << 28, 1'b0, '0);
        for (int k = 1; k <= 4; k++) pop_chk("R9 order", 32'(k));
        @(negedge clk);
        check("R9 fifth dropped", {31'b0, rd_valid}, 32'd0);

        // R9 push and pop on the same edge
        xfer(32'h0, 32'h6000_0000, 1'b0, '0);
        xfer(32'h0, 32'h7000_0000, 1'b1, 32'h6);
        pop_chk("R9 new head", 32'h7);
        @(negedge clk);
        check("R9 emptied", {31'b0, rd_valid}, 32'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule